// File: doc/BRIEF.md
# Fairness-Aware DRAM Request Picker

This block picks one request per DRAM cycle from a shared memory request queue that serves several hardware threads. Every queue slot carries a valid flag, the owning thread, a bank number, a row number and an age stamp. A smaller stamp means an older request. Every bank reports whether a row is open and which row it is. Every thread provides a fixed-point slowdown figure and an integer weight. The product of the two is the thread's weighted slowdown.

Only threads that own at least one valid slot take part. From those threads the block finds the largest and the smallest weighted slowdown. It compares their ratio with a programmable limit, and the comparison uses no divider. When the ratio is below the limit, the block uses throughput order: row hits first, then the oldest request. When the ratio is at or above the limit, it uses fairness order: the thread with the largest weighted slowdown first, then row hits, then the oldest request. The chosen slot index and the mode in force are registered and appear one clock after the inputs.

Top module: `stfm_picker`

## Requirements
- R1: While reset is high, and in the first cycle after it, `grant_valid` and `grant_fair` are 0.
- R2: If no slot is valid at a clock edge, `grant_valid` is 0 after that edge.
- R3: In throughput mode, a slot whose row equals the open row of its bank wins over any slot that misses. A hit also requires that bank's `bank_open` bit to be 1.
- R4: Among slots that rank equally on the earlier keys, the smallest age stamp wins. If ages are equal too, the lowest slot index wins.
- R5: A thread that owns no valid slot is left out of the largest/smallest slowdown search, whatever its slowdown.
- R6: Fairness mode is selected when `max_ws * 2^LIM_FRAC >= unfair_limit * min_ws`. Here `unfair_limit` is unsigned fixed point with LIM_FRAC fraction bits. Equality selects fairness mode; anything below selects throughput mode. `grant_fair` shows the mode used for the grant.
- R7: In fairness mode, slots of the thread with the largest weighted slowdown win over all others. If two threads tie, the lower thread number is taken. Inside that thread, row hits win first, then the oldest slot.
- R8: A thread's weighted slowdown is `slowdown * weight`, and the comparison in R6 and R7 uses this product.
- R9: When one thread alone has valid slots, the ratio counts as 1.0. Fairness mode is then used exactly when `unfair_limit <= 2^LIM_FRAC`.
- R10: The grant for the inputs present at clock edge k appears right after edge k. It holds unchanged until edge k+1, and at most one slot is granted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM-cycle clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | NUM_REQ | slot holds a legal request |
| req_thread | input | NUM_REQ*TID_W | owning thread per slot |
| req_bank | input | NUM_REQ*BANK_W | target bank per slot |
| req_row | input | NUM_REQ*ROW_W | target row per slot |
| req_age | input | NUM_REQ*AGE_W | age stamp per slot, smaller is older |
| bank_open | input | NUM_BANK | bank has an open row |
| bank_row | input | NUM_BANK*ROW_W | open row per bank |
| thr_slowdown | input | NUM_THR*SLOW_W | fixed-point slowdown per thread |
| thr_weight | input | NUM_THR*WGT_W | weight per thread |
| unfair_limit | input | LIM_W | unfairness limit, LIM_FRAC fraction bits |
| grant_valid | output | 1 | a slot was chosen |
| grant_idx | output | IDX_W | index of the chosen slot |
| grant_fair | output | 1 | the grant used fairness order |

## Verification
In a single cycle the mode decision and the row-hit ranking can pull in opposite directions. The most slowed thread may hold only row misses while another thread holds an older row hit. The bench builds exactly this case with the ratio at, just above and just below the limit. It then checks that the winner flips between the two slots as the mode flips. A second clash arises when an idle thread carries an extreme slowdown next to the active threads. There the bench checks that the mode and the winner stay as the active threads alone dictate.

// File: rtl/stfm_pkg.sv
package stfm_pkg;
  // Number of bits needed to index n items, at least 1.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/stfm_thread_stats.sv
module stfm_thread_stats
  import stfm_pkg::*;
#(
  parameter int NUM_REQ  = 128,
  parameter int NUM_THR  = 8,
  parameter int SLOW_W   = 12,
  parameter int WGT_W    = 4,
  parameter int LIM_W    = 12,
  parameter int LIM_FRAC = 8,
  localparam int TID_W = idx_bits(NUM_THR),
  localparam int WS_W  = SLOW_W + WGT_W
) (
  input  logic [NUM_REQ-1:0]        req_valid,
  input  logic [NUM_REQ*TID_W-1:0]  req_thread,
  input  logic [NUM_THR*SLOW_W-1:0] thr_slowdown,
  input  logic [NUM_THR*WGT_W-1:0]  thr_weight,
  input  logic [LIM_W-1:0]          unfair_limit,
  output logic                      fair_mode,
  output logic [TID_W-1:0]          top_thread
);
  localparam int CMP_W = WS_W + LIM_W + LIM_FRAC;

  logic [NUM_THR-1:0] active;
  logic [WS_W-1:0]    ws [NUM_THR];
  logic [WS_W-1:0]    ws_max, ws_min;
  logic               any_active;
  logic [CMP_W-1:0]   lhs, rhs;

  // Weighted slowdown per thread.
  for (genvar t = 0; t < NUM_THR; t++) begin : g_ws
    assign ws[t] = WS_W'(thr_slowdown[t*SLOW_W +: SLOW_W]) *
                   WS_W'(thr_weight[t*WGT_W +: WGT_W]);
  end

  // A thread is active when it owns at least one valid slot.
  always_comb begin
    active = '0;
    for (int e = 0; e < NUM_REQ; e++)
      if (req_valid[e])
        active[req_thread[e*TID_W +: TID_W]] = 1'b1;
  end

  // Extremes over the active threads; ties keep the lower thread number.
  always_comb begin
    ws_max     = '0;
    ws_min     = '1;
    top_thread = '0;
    any_active = 1'b0;
    for (int t = 0; t < NUM_THR; t++) begin
      if (active[t]) begin
        if (!any_active || ws[t] > ws_max) begin
          ws_max     = ws[t];
          top_thread = TID_W'(t);
        end
        if (!any_active || ws[t] < ws_min)
          ws_min = ws[t];
        any_active = 1'b1;
      end
    end
  end

  // Divider-free ratio test: max * 2^F >= limit * min.
  assign lhs = CMP_W'(ws_max) << LIM_FRAC;
  assign rhs = CMP_W'(unfair_limit) * CMP_W'(ws_min);
  assign fair_mode = any_active && (lhs >= rhs);
endmodule

// File: rtl/stfm_slot_rank.sv
module stfm_slot_rank
  import stfm_pkg::*;
#(
  parameter int NUM_THR  = 8,
  parameter int NUM_BANK = 8,
  parameter int ROW_W    = 14,
  parameter int AGE_W    = 10,
  localparam int TID_W  = idx_bits(NUM_THR),
  localparam int BANK_W = idx_bits(NUM_BANK),
  localparam int KEY_W  = 3 + AGE_W
) (
  input  logic                      valid,
  input  logic [TID_W-1:0]          thread,
  input  logic [BANK_W-1:0]         bank,
  input  logic [ROW_W-1:0]          row,
  input  logic [AGE_W-1:0]          age,
  input  logic [NUM_BANK-1:0]       bank_open,
  input  logic [NUM_BANK*ROW_W-1:0] bank_row,
  input  logic                      fair_mode,
  input  logic [TID_W-1:0]          top_thread,
  output logic [KEY_W-1:0]          key
);
  logic hit, favoured;

  assign hit      = bank_open[bank] && (bank_row[bank*ROW_W +: ROW_W] == row);
  assign favoured = fair_mode && (thread == top_thread);
  // Larger key wins: validity, fairness favour, row hit, then age (inverted).
  assign key = {valid, favoured, hit, ~age};
endmodule

// File: rtl/stfm_picker.sv
module stfm_picker
  import stfm_pkg::*;
#(
  parameter int NUM_REQ  = 128,
  parameter int NUM_THR  = 8,
  parameter int NUM_BANK = 8,
  parameter int ROW_W    = 14,
  parameter int AGE_W    = 10,
  parameter int SLOW_W   = 12,
  parameter int WGT_W    = 4,
  parameter int LIM_W    = 12,
  parameter int LIM_FRAC = 8,
  localparam int TID_W  = idx_bits(NUM_THR),
  localparam int BANK_W = idx_bits(NUM_BANK),
  localparam int IDX_W  = idx_bits(NUM_REQ)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_REQ-1:0]          req_valid,
  input  logic [NUM_REQ*TID_W-1:0]    req_thread,
  input  logic [NUM_REQ*BANK_W-1:0]   req_bank,
  input  logic [NUM_REQ*ROW_W-1:0]    req_row,
  input  logic [NUM_REQ*AGE_W-1:0]    req_age,
  input  logic [NUM_BANK-1:0]         bank_open,
  input  logic [NUM_BANK*ROW_W-1:0]   bank_row,
  input  logic [NUM_THR*SLOW_W-1:0]   thr_slowdown,
  input  logic [NUM_THR*WGT_W-1:0]    thr_weight,
  input  logic [LIM_W-1:0]            unfair_limit,
  output logic                        grant_valid,
  output logic [IDX_W-1:0]            grant_idx,
  output logic                        grant_fair
);
  localparam int KEY_W = 3 + AGE_W;

  logic             fair_mode;
  logic [TID_W-1:0] top_thread;
  logic [KEY_W-1:0] key [NUM_REQ];
  logic [KEY_W-1:0] best_key;
  logic [IDX_W-1:0] best_idx;

  stfm_thread_stats #(
    .NUM_REQ(NUM_REQ), .NUM_THR(NUM_THR), .SLOW_W(SLOW_W),
    .WGT_W(WGT_W), .LIM_W(LIM_W), .LIM_FRAC(LIM_FRAC)
  ) u_stats (
    .req_valid(req_valid), .req_thread(req_thread),
    .thr_slowdown(thr_slowdown), .thr_weight(thr_weight),
    .unfair_limit(unfair_limit), .fair_mode(fair_mode),
    .top_thread(top_thread)
  );

  for (genvar e = 0; e < NUM_REQ; e++) begin : g_slot
    stfm_slot_rank #(
      .NUM_THR(NUM_THR), .NUM_BANK(NUM_BANK), .ROW_W(ROW_W), .AGE_W(AGE_W)
    ) u_rank (
      .valid(req_valid[e]),
      .thread(req_thread[e*TID_W +: TID_W]),
      .bank(req_bank[e*BANK_W +: BANK_W]),
      .row(req_row[e*ROW_W +: ROW_W]),
      .age(req_age[e*AGE_W +: AGE_W]),
      .bank_open(bank_open), .bank_row(bank_row),
      .fair_mode(fair_mode), .top_thread(top_thread),
      .key(key[e])
    );
  end

  // Strictly-greater scan keeps the lowest index on equal keys.
  always_comb begin
    best_key = key[0];
    best_idx = '0;
    for (int e = 1; e < NUM_REQ; e++)
      if (key[e] > best_key) begin
        best_key = key[e];
        best_idx = IDX_W'(e);
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
      grant_fair  <= 1'b0;
    end else begin
      grant_valid <= best_key[KEY_W-1];
      grant_idx   <= best_idx;
      grant_fair  <= fair_mode && best_key[KEY_W-1];
    end
  end
endmodule

// File: rtl/stfm_picker_chk.sv
module stfm_picker_chk
  import stfm_pkg::*;
#(
  parameter int NUM_REQ  = 128,
  parameter int LIM_W    = 12,
  parameter int LIM_FRAC = 8,
  localparam int IDX_W = idx_bits(NUM_REQ)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] req_valid,
  input logic [LIM_W-1:0]   unfair_limit,
  input logic               grant_valid,
  input logic [IDX_W-1:0]   grant_idx,
  input logic               grant_fair
);
  logic               seen;
  logic [NUM_REQ-1:0] prev_valid;
  logic               prev_low_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen           <= 1'b0;
      prev_valid     <= '0;
      prev_low_limit <= 1'b0;
    end else begin
      seen           <= 1'b1;
      prev_valid     <= req_valid;
      prev_low_limit <= (unfair_limit <= LIM_W'(1 << LIM_FRAC));
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !grant_valid && !grant_fair); // R1
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (seen && prev_valid == '0) |-> !grant_valid); // R2
  AST_GRANT_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> prev_valid[grant_idx]); // R10
  AST_FAIR_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    grant_fair |-> grant_valid); // R6
  AST_LOW_LIMIT_FAIR: assert property (@(posedge clk) disable iff (rst)
    (seen && prev_low_limit && prev_valid != '0) |-> grant_fair); // R9
endmodule

bind stfm_picker stfm_picker_chk #(
  .NUM_REQ(NUM_REQ), .LIM_W(LIM_W), .LIM_FRAC(LIM_FRAC)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .unfair_limit(unfair_limit),
  .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_fair(grant_fair)
);

// File: tb/stfm_picker_test.sv
module stfm_picker_test;
  localparam int E = 8, T = 4, B = 4, RW = 8, AW = 8, SW = 8, WW = 4, LW = 8, F = 4;
  localparam int TW = 2, BW = 2, IW = 3;

  logic clk = 0, rst = 1;
  logic [E-1:0]    req_valid;
  logic [E*TW-1:0] req_thread;
  logic [E*BW-1:0] req_bank;
  logic [E*RW-1:0] req_row;
  logic [E*AW-1:0] req_age;
  logic [B-1:0]    bank_open;
  logic [B*RW-1:0] bank_row;
  logic [T*SW-1:0] thr_slowdown;
  logic [T*WW-1:0] thr_weight;
  logic [LW-1:0]   unfair_limit;
  logic            grant_valid, grant_fair;
  logic [IW-1:0]   grant_idx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stfm_picker #(.NUM_REQ(E), .NUM_THR(T), .NUM_BANK(B), .ROW_W(RW), .AGE_W(AW),
    .SLOW_W(SW), .WGT_W(WW), .LIM_W(LW), .LIM_FRAC(F)) uut (.*);

  task automatic step(); @(posedge clk); #1; endtask

  task automatic check(string tag, logic v, logic [IW-1:0] idx, logic fm);
    checks++;
    if (grant_valid !== v || (v && grant_idx !== idx) || grant_fair !== fm) begin
      errors++;
      $display("FAIL %s: got v=%0b idx=%0d fair=%0b expected v=%0b idx=%0d fair=%0b",
               tag, grant_valid, grant_idx, grant_fair, v, idx, fm);
    end
  endtask

  task automatic clear();
    req_valid = '0; req_thread = '0; req_bank = '0; req_row = '0; req_age = '0;
    bank_open = '1; bank_row = '0;
    for (int t = 0; t < T; t++) begin
      thr_slowdown[t*SW +: SW] = 8'd16;
      thr_weight[t*WW +: WW] = 4'd1;
    end
    unfair_limit = 8'd255;
  endtask

  task automatic put(int i, int thr, int bank, int row, int age);
    req_valid[i] = 1'b1;
    req_thread[i*TW +: TW] = TW'(thr);
    req_bank[i*BW +: BW] = BW'(bank);
    req_row[i*RW +: RW] = RW'(row);
    req_age[i*AW +: AW] = AW'(age);
  endtask

  task automatic t_reset();
    check("R1 in reset", 0, 0, 0);
    rst = 0; step();
    check("R1 after reset", 0, 0, 0);
  endtask

  task automatic t_idle();
    clear(); put(2, 0, 0, 1, 1); step();
    clear(); step();
    check("R2 no valid slot", 0, 0, 0);
  endtask

  task automatic t_hit();
    clear(); bank_row[0 +: RW] = 8'd3;
    put(0, 0, 0, 5, 1); put(3, 1, 0, 3, 9); step();
    check("R3 hit beats older miss", 1, 3, 0);
    bank_open[0] = 1'b0; step();
    check("R3 closed bank no hit", 1, 0, 0);
  endtask

  task automatic t_age();
    clear(); bank_row = '1;
    put(2, 0, 1, 4, 4); put(5, 1, 2, 4, 2); step();
    check("R4 oldest wins", 1, 5, 0);
    clear(); bank_row = '1;
    put(6, 0, 1, 4, 3); put(1, 2, 2, 4, 3); step();
    check("R4 equal age low index", 1, 1, 0);
  endtask

  task automatic t_fair();
    clear(); bank_row[0 +: RW] = 8'd7;
    thr_slowdown[0 +: SW] = 8'd40; unfair_limit = 8'd32;
    put(1, 1, 0, 7, 0); put(4, 0, 1, 9, 7); put(6, 0, 2, 9, 5); step();
    check("R7 top thread oldest", 1, 6, 1);
    bank_row[3*RW +: RW] = 8'd9; put(7, 0, 3, 9, 9); step();
    check("R7 top thread hit first", 1, 7, 1);
  endtask

  task automatic t_boundary();
    clear(); bank_row[0 +: RW] = 8'd7;
    thr_slowdown[0 +: SW] = 8'd32; unfair_limit = 8'd32;
    put(1, 1, 0, 7, 3); put(4, 0, 1, 9, 0); step();
    check("R6 ratio equal limit", 1, 4, 1);
    unfair_limit = 8'd33; step();
    check("R6 ratio below limit", 1, 1, 0);
  endtask

  task automatic t_idle_thread();
    clear(); bank_row[0 +: RW] = 8'd7;
    thr_slowdown[2*SW +: SW] = 8'd200; unfair_limit = 8'd32;
    put(0, 0, 1, 9, 0); put(5, 1, 0, 7, 4); step();
    check("R5 idle thread ignored", 1, 5, 0);
  endtask

  task automatic t_weight();
    clear(); bank_row[0 +: RW] = 8'd7;
    thr_weight[1*WW +: WW] = 4'd3; unfair_limit = 8'd32;
    put(0, 0, 0, 7, 0); put(2, 1, 1, 9, 5); step();
    check("R8 weight favours thread", 1, 2, 1);
  endtask

  task automatic t_single();
    clear(); put(3, 3, 0, 1, 2); put(6, 3, 1, 1, 1); unfair_limit = 8'd16; step();
    check("R9 single thread limit 1.0", 1, 6, 1);
    unfair_limit = 8'd17; step();
    check("R9 single thread limit above 1.0", 1, 6, 0);
  endtask

  task automatic t_latency();
    clear(); put(2, 0, 0, 1, 1); step();
    check("R10 first grant", 1, 2, 0);
    clear(); put(5, 1, 0, 1, 1); #5;
    check("R10 holds until edge", 1, 2, 0);
    @(posedge clk); #1;
    check("R10 next grant", 1, 5, 0);
  endtask

  initial begin
    clear();
    repeat (3) @(posedge clk); #1;
    t_reset(); t_idle(); t_hit(); t_age(); t_fair(); t_boundary();
    t_idle_thread(); t_weight(); t_single(); t_latency();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule